// File: doc/BRIEF.md
# Shared Control and Status Register Bank with Two Access Ports

This block holds a small set of 64-bit control and status registers that two requesters reach through separate ports. The configuration port addresses registers by word: its byte address shifted right by three is the register index. The memory-mapped port also uses byte addresses, but its window begins at the base-address register, so its index is the shifted address plus a fixed bias of 0x0A. Both ports reach the same storage. Reads from unimplemented locations return all ones.

Several indices are write-only aliases that change another register. Two aliases AND or OR into the fault register. Two aliases set or clear bits in the control register. The base-address register accepts writes only from the configuration port. The service-processor base register keeps only its address bits. The interrupt status register mirrors a status input and cannot be written. Each accepted access is answered one cycle later with an acknowledge, read data and an error flag. A one-cycle pulse reports every change of the memory-mapped-enable bit of the control register. When both ports write in the same cycle, the configuration port wins and the memory-mapped port is held off for that cycle.

Top module: `dual_regbank`

## Requirements
- R1: The configuration port index is `cfg_addr >> 3`. The memory-mapped port index is `(mm_addr >> 3) + 0x0A`, taken modulo 256. So memory-mapped byte 0x00 reaches index 0x0A, and byte 0x58 reaches index 0x15.
- R2: Index 0x00 is the fault register and a write replaces its contents. A write to index 0x01 ANDs the data into it. A write to index 0x02 ORs the data into it.
- R3: Index 0x0E is the control register and a write replaces its contents. A write to index 0x12 sets the written 1 bits. A write to index 0x13 clears the written 1 bits.
- R4: Index 0x0A is the base-address register. It keeps only data bits 20 to 49 and enable bit 0, and all other bits read as zero. A write to it from the memory-mapped port leaves it unchanged and raises the error flag.
- R5: Index 0x0B is the service-processor base register. It keeps only data bits 32 to 49.
- R6: Index 0x15 reads the value of `stat_in` that was sampled at the previous clock edge. A write to index 0x15 changes nothing and raises the error flag.
- R7: A read of any index other than 0x00, 0x0A, 0x0B, 0x0E and 0x15 returns all ones without an error. The alias indices read as all ones. A write to an index with no function changes nothing and raises no error.
- R8: An access is well formed only when its size code is 8 and its address bits [2:0] are zero. An access that is not well formed changes no register, raises the error flag, and a read returns all ones.
- R9: After synchronous reset all registers read zero, with one exception. The base-address register reads `BASE_RESET` masked to bits 20 to 49, with bit 0 set. The acknowledge and error outputs are low.
- R10: `mmen_flip` is high for exactly the one cycle after a clock edge at which bit 62 of the control register changes value.
- R11: When both ports request a write in the same cycle, `mm_gnt` is low. The configuration write takes effect. The memory-mapped write takes no effect and gets no acknowledge until it is presented again.
- R12: An accepted access raises its port's `*_ack` in the following cycle. In that same cycle the port shows `*_err` and, for a read, `*_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Configuration port access request |
| cfg_we | input | 1 | Configuration port write (1) or read (0) |
| cfg_addr | input | ADDR_W | Configuration port byte address |
| cfg_size | input | 4 | Configuration access size in bytes |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_ack | output | 1 | Configuration response valid |
| cfg_err | output | 1 | Configuration access error |
| cfg_rdata | output | 64 | Configuration read data |
| mm_req | input | 1 | Memory-mapped port access request |
| mm_we | input | 1 | Memory-mapped write (1) or read (0) |
| mm_addr | input | ADDR_W | Memory-mapped byte address |
| mm_size | input | 4 | Memory-mapped access size in bytes |
| mm_wdata | input | 64 | Memory-mapped write data |
| mm_gnt | output | 1 | Memory-mapped request accepted this cycle |
| mm_ack | output | 1 | Memory-mapped response valid |
| mm_err | output | 1 | Memory-mapped access error |
| mm_rdata | output | 64 | Memory-mapped read data |
| stat_in | input | 64 | Live interrupt status sampled into index 0x15 |
| mmen_flip | output | 1 | Pulse on a change of control bit 62 |

## Verification
The bench sends writes to the base-address register through the memory-mapped port. A design that forgot which port the write came from would move the window and report no error. It uses the aliases with patterns where AND, OR, set and clear give different results, so that swapping any two of them changes the read-back value. It issues misaligned and wrong-size accesses, and it reads alias and empty indices, where a design that defaulted to zero or to the backing register would be caught. It also makes both ports write in the same cycle to check that the memory-mapped write is neither lost on retry nor applied twice. Throughout, it tracks bit 62 so that a missing or extra toggle pulse shows up.

// File: rtl/dual_regbank_pkg.sv
package dual_regbank_pkg;

    localparam int IDX_W     = 8;
    localparam int DATA_W    = 64;
    localparam int WORD_SIZE = 8;

    localparam logic [IDX_W-1:0] IX_FAULT     = 8'h00;
    localparam logic [IDX_W-1:0] IX_FAULT_AND = 8'h01;
    localparam logic [IDX_W-1:0] IX_FAULT_OR  = 8'h02;
    localparam logic [IDX_W-1:0] IX_BASE      = 8'h0A;
    localparam logic [IDX_W-1:0] IX_SPBASE    = 8'h0B;
    localparam logic [IDX_W-1:0] IX_CTRL      = 8'h0E;
    localparam logic [IDX_W-1:0] IX_CTRL_SET  = 8'h12;
    localparam logic [IDX_W-1:0] IX_CTRL_CLR  = 8'h13;
    localparam logic [IDX_W-1:0] IX_STAT      = 8'h15;
    localparam logic [IDX_W-1:0] MM_BIAS      = IX_BASE;

    localparam logic [DATA_W-1:0] BASE_KEEP   = 64'h0003_FFFF_FFF0_0000;
    localparam logic [DATA_W-1:0] BASE_ENABLE = 64'h0000_0000_0000_0001;
    localparam logic [DATA_W-1:0] SPBASE_KEEP = 64'h0003_FFFF_0000_0000;
    localparam int                MMEN_BIT    = 62;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_FAULT_WR,
        OP_FAULT_AND,
        OP_FAULT_OR,
        OP_BASE_WR,
        OP_SPBASE_WR,
        OP_CTRL_WR,
        OP_CTRL_SET,
        OP_CTRL_CLR,
        OP_REJECT
    } wr_op_e;

    typedef struct packed {
        wr_op_e              op;
        logic [DATA_W-1:0]   data;
    } wr_cmd_t;

    // Map a write target to its effect; the origin port matters for the base register.
    function automatic wr_op_e classify_write(input logic [IDX_W-1:0] idx, input logic from_mm);
        wr_op_e op;
        case (idx)
            IX_FAULT:     op = OP_FAULT_WR;
            IX_FAULT_AND: op = OP_FAULT_AND;
            IX_FAULT_OR:  op = OP_FAULT_OR;
            IX_BASE:      op = from_mm ? OP_REJECT : OP_BASE_WR;
            IX_SPBASE:    op = OP_SPBASE_WR;
            IX_CTRL:      op = OP_CTRL_WR;
            IX_CTRL_SET:  op = OP_CTRL_SET;
            IX_CTRL_CLR:  op = OP_CTRL_CLR;
            IX_STAT:      op = OP_REJECT;
            default:      op = OP_NONE;
        endcase
        return op;
    endfunction

    function automatic logic op_applies(input wr_op_e op);
        return (op != OP_NONE) && (op != OP_REJECT);
    endfunction

endpackage

// File: rtl/rb_port_decode.sv
module rb_port_decode
    import dual_regbank_pkg::*;
#(
    parameter int               ADDR_W = 11,
    parameter logic [IDX_W-1:0] BIAS   = '0,
    parameter bit               IS_MM  = 1'b0
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic              gnt,
    output logic [IDX_W-1:0]  idx,
    output logic              take,
    output logic              well_formed,
    output wr_cmd_t           cmd,
    output logic              err_d
);
    always_comb begin
        idx         = IDX_W'(addr >> 3) + BIAS;
        take        = req & gnt;
        well_formed = (size == 4'(WORD_SIZE)) && (addr[2:0] == 3'b000);
        cmd.data    = wdata;
        cmd.op      = (take && we && well_formed) ? classify_write(idx, IS_MM) : OP_NONE;
        err_d       = take && (!well_formed || (cmd.op == OP_REJECT));
    end
endmodule

// File: rtl/rb_regfile.sv
module rb_regfile
    import dual_regbank_pkg::*;
#(
    parameter int                NRD        = 2,
    parameter logic [DATA_W-1:0] BASE_RESET = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  wr_cmd_t                    wr,
    input  logic [DATA_W-1:0]          stat_in,
    input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NRD-1:0][DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0]          fault_q,
    output logic [DATA_W-1:0]          base_q,
    output logic [DATA_W-1:0]          spbase_q,
    output logic [DATA_W-1:0]          ctrl_q,
    output logic [DATA_W-1:0]          stat_q,
    output logic                       mmen_flip
);
    localparam logic [DATA_W-1:0] BASE_INIT = (BASE_RESET & BASE_KEEP) | BASE_ENABLE;

    logic [DATA_W-1:0] fault_d, base_d, spbase_d, ctrl_d;

    always_comb begin
        fault_d  = fault_q;
        base_d   = base_q;
        spbase_d = spbase_q;
        ctrl_d   = ctrl_q;
        case (wr.op)
            OP_FAULT_WR:  fault_d  = wr.data;
            OP_FAULT_AND: fault_d  = fault_q & wr.data;
            OP_FAULT_OR:  fault_d  = fault_q | wr.data;
            OP_BASE_WR:   base_d   = wr.data & (BASE_KEEP | BASE_ENABLE);
            OP_SPBASE_WR: spbase_d = wr.data & SPBASE_KEEP;
            OP_CTRL_WR:   ctrl_d   = wr.data;
            OP_CTRL_SET:  ctrl_d   = ctrl_q | wr.data;
            OP_CTRL_CLR:  ctrl_d   = ctrl_q & ~wr.data;
            default:      ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q   <= '0;
            base_q    <= BASE_INIT;
            spbase_q  <= '0;
            ctrl_q    <= '0;
            stat_q    <= '0;
            mmen_flip <= 1'b0;
        end else begin
            fault_q   <= fault_d;
            base_q    <= base_d;
            spbase_q  <= spbase_d;
            ctrl_q    <= ctrl_d;
            stat_q    <= stat_in;
            mmen_flip <= ctrl_d[MMEN_BIT] ^ ctrl_q[MMEN_BIT];
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            case (rd_idx[p])
                IX_FAULT:  rd_val[p] = fault_q;
                IX_BASE:   rd_val[p] = base_q;
                IX_SPBASE: rd_val[p] = spbase_q;
                IX_CTRL:   rd_val[p] = ctrl_q;
                IX_STAT:   rd_val[p] = stat_q;
                default:   rd_val[p] = '1;
            endcase
        end
    end
endmodule

// File: rtl/rb_port_resp.sv
module rb_port_resp
    import dual_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              we,
    input  logic              well_formed,
    input  logic              err_d,
    input  logic [DATA_W-1:0] rd_val,
    output logic              ack_q,
    output logic              err_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q <= take;
            err_q <= err_d;
            if (take && !we) begin
                rdata_q <= well_formed ? rd_val : '1;
            end
        end
    end
endmodule

// File: rtl/dual_regbank.sv
module dual_regbank
    import dual_regbank_pkg::*;
#(
    parameter int          ADDR_W     = 11,
    parameter logic [63:0] BASE_RESET = 64'h0000_0012_3450_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_size,
    input  logic [63:0]       cfg_wdata,
    output logic              cfg_ack,
    output logic              cfg_err,
    output logic [63:0]       cfg_rdata,
    input  logic              mm_req,
    input  logic              mm_we,
    input  logic [ADDR_W-1:0] mm_addr,
    input  logic [3:0]        mm_size,
    input  logic [63:0]       mm_wdata,
    output logic              mm_gnt,
    output logic              mm_ack,
    output logic              mm_err,
    output logic [63:0]       mm_rdata,
    input  logic [63:0]       stat_in,
    output logic              mmen_flip
);
    localparam int NRD = 2;

    logic [IDX_W-1:0] cfg_idx, mm_idx;
    logic             cfg_take, mm_take, cfg_ok, mm_ok, cfg_err_d, mm_err_d;
    wr_cmd_t          cfg_cmd, mm_cmd, win_cmd;
    logic [NRD-1:0][IDX_W-1:0]  rd_idx;
    logic [NRD-1:0][DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] fault_q, base_q, spbase_q, ctrl_q, stat_q;

    // Configuration writes take precedence; a colliding memory-mapped write waits.
    assign mm_gnt = !(cfg_req && cfg_we && mm_req && mm_we);

    rb_port_decode #(.ADDR_W(ADDR_W), .BIAS('0), .IS_MM(1'b0)) u_cfg_dec (
        .req(cfg_req), .we(cfg_we), .addr(cfg_addr), .size(cfg_size), .wdata(cfg_wdata),
        .gnt(1'b1), .idx(cfg_idx), .take(cfg_take), .well_formed(cfg_ok),
        .cmd(cfg_cmd), .err_d(cfg_err_d)
    );

    rb_port_decode #(.ADDR_W(ADDR_W), .BIAS(MM_BIAS), .IS_MM(1'b1)) u_mm_dec (
        .req(mm_req), .we(mm_we), .addr(mm_addr), .size(mm_size), .wdata(mm_wdata),
        .gnt(mm_gnt), .idx(mm_idx), .take(mm_take), .well_formed(mm_ok),
        .cmd(mm_cmd), .err_d(mm_err_d)
    );

    always_comb begin
        win_cmd   = op_applies(cfg_cmd.op) ? cfg_cmd : mm_cmd;
        rd_idx[0] = cfg_idx;
        rd_idx[1] = mm_idx;
    end

    rb_regfile #(.NRD(NRD), .BASE_RESET(BASE_RESET)) u_file (
        .clk(clk), .rst(rst), .wr(win_cmd), .stat_in(stat_in),
        .rd_idx(rd_idx), .rd_val(rd_val),
        .fault_q(fault_q), .base_q(base_q), .spbase_q(spbase_q),
        .ctrl_q(ctrl_q), .stat_q(stat_q), .mmen_flip(mmen_flip)
    );

    rb_port_resp u_cfg_resp (
        .clk(clk), .rst(rst), .take(cfg_take), .we(cfg_we), .well_formed(cfg_ok),
        .err_d(cfg_err_d), .rd_val(rd_val[0]),
        .ack_q(cfg_ack), .err_q(cfg_err), .rdata_q(cfg_rdata)
    );

    rb_port_resp u_mm_resp (
        .clk(clk), .rst(rst), .take(mm_take), .we(mm_we), .well_formed(mm_ok),
        .err_d(mm_err_d), .rd_val(rd_val[1]),
        .ack_q(mm_ack), .err_q(mm_err), .rdata_q(mm_rdata)
    );
endmodule

// File: rtl/rb_checker.sv
module rb_checker
    import dual_regbank_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_req,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [3:0]        cfg_size,
    input logic              cfg_ack,
    input logic              cfg_err,
    input logic [63:0]       cfg_rdata,
    input logic              mm_req,
    input logic              mm_we,
    input logic [ADDR_W-1:0] mm_addr,
    input logic [3:0]        mm_size,
    input logic              mm_gnt,
    input logic              mm_ack,
    input logic              mm_err,
    input logic [63:0]       base_q,
    input logic [63:0]       spbase_q,
    input logic [63:0]       ctrl_q,
    input logic              mmen_flip
);
    logic             seen;
    logic [IDX_W-1:0] c_idx, m_idx;
    logic             c_good, m_good;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    always_comb begin
        c_idx  = IDX_W'(cfg_addr >> 3);
        m_idx  = IDX_W'(mm_addr >> 3) + 8'h0A;
        c_good = (cfg_size == 4'd8) && (cfg_addr[2:0] == 3'b000);
        m_good = (mm_size == 4'd8) && (mm_addr[2:0] == 3'b000);
    end

    p_base_bits_r4: assert property (@(posedge clk) disable iff (rst)
        (base_q & ~64'h0003_FFFF_FFF0_0001) == 64'h0);

    p_mm_base_locked_r4: assert property (@(posedge clk) disable iff (rst)
        (mm_req && mm_we && mm_gnt && m_good && m_idx == 8'h0A) |=> ($stable(base_q) && mm_err));

    p_spbase_bits_r5: assert property (@(posedge clk) disable iff (rst)
        (spbase_q & ~64'h0003_FFFF_0000_0000) == 64'h0);

    p_stat_readonly_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && cfg_we && c_good && c_idx == 8'h15) |=> cfg_err);

    p_alias_reads_ones_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_we && c_good && c_idx == 8'h01) |=> (cfg_rdata == 64'hFFFF_FFFF_FFFF_FFFF && !cfg_err));

    p_malformed_err_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !c_good) |=> (cfg_ack && cfg_err));

    p_flip_tracks_r10: assert property (@(posedge clk) disable iff (rst)
        (seen && mmen_flip) |-> (ctrl_q[62] != $past(ctrl_q[62])));

    p_stalled_no_ack_r11: assert property (@(posedge clk) disable iff (rst)
        (mm_req && mm_we && !mm_gnt) |=> !mm_ack);

    p_cfg_ack_next_r12: assert property (@(posedge clk) disable iff (rst)
        cfg_req |=> cfg_ack);
endmodule

bind dual_regbank rb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_size(cfg_size),
    .cfg_ack(cfg_ack), .cfg_err(cfg_err), .cfg_rdata(cfg_rdata),
    .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_size(mm_size),
    .mm_gnt(mm_gnt), .mm_ack(mm_ack), .mm_err(mm_err),
    .base_q(base_q), .spbase_q(spbase_q), .ctrl_q(ctrl_q), .mmen_flip(mmen_flip)
);

// File: tb/dual_regbank_tb.sv
module dual_regbank_tb;
    localparam int          AW       = 11;
    localparam logic [63:0] BRST     = 64'h0000_0012_3450_0000;
    localparam logic [63:0] ONES     = 64'hFFFF_FFFF_FFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_req, cfg_we, mm_req, mm_we;
    logic [AW-1:0] cfg_addr, mm_addr;
    logic [3:0]    cfg_size, mm_size;
    logic [63:0]   cfg_wdata, mm_wdata, stat_in;
    logic          cfg_ack, cfg_err, mm_gnt, mm_ack, mm_err, mmen_flip;
    logic [63:0]   cfg_rdata, mm_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    logic [63:0] m_fault, m_base, m_spbase, m_ctrl, m_stat;

    always #2 clk = ~clk;

    dual_regbank #(.ADDR_W(AW), .BASE_RESET(BRST)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_size(cfg_size),
        .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_err(cfg_err), .cfg_rdata(cfg_rdata),
        .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_size(mm_size),
        .mm_wdata(mm_wdata), .mm_gnt(mm_gnt), .mm_ack(mm_ack), .mm_err(mm_err),
        .mm_rdata(mm_rdata), .stat_in(stat_in), .mmen_flip(mmen_flip)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mdl_read(input logic [7:0] idx);
        case (idx)
            8'h00:   return m_fault;
            8'h0A:   return m_base;
            8'h0B:   return m_spbase;
            8'h0E:   return m_ctrl;
            8'h15:   return m_stat;
            default: return ONES;
        endcase
    endfunction

    // applies a well-formed write to the model, returns the expected error flag
    function automatic bit mdl_write(input logic [7:0] idx, input logic [63:0] d, input bit mm);
        case (idx)
            8'h00: m_fault  = d;
            8'h01: m_fault  = m_fault & d;
            8'h02: m_fault  = m_fault | d;
            8'h0A: begin
                if (mm) return 1'b1;
                m_base = d & 64'h0003_FFFF_FFF0_0001;
            end
            8'h0B: m_spbase = d & 64'h0003_FFFF_0000_0000;
            8'h0E: m_ctrl   = d;
            8'h12: m_ctrl   = m_ctrl | d;
            8'h13: m_ctrl   = m_ctrl & ~d;
            8'h15: return 1'b1;
            default: ;
        endcase
        return 1'b0;
    endfunction

    function automatic logic [AW-1:0] addr_of(input logic [7:0] idx, input bit mm);
        logic [7:0] w;
        w = mm ? (idx - 8'h0A) : idx;
        return AW'({w, 3'b000});
    endfunction

    // one access on one port; responses checked in the following cycle
    task automatic access(input bit mm, input bit we, input logic [AW-1:0] addr,
                          input logic [3:0] size, input logic [63:0] d, input string tag);
        logic [7:0]  idx;
        bit          good, exp_err;
        logic [63:0] exp_rd;
        logic        old62;
        idx  = mm ? (8'(addr >> 3) + 8'h0A) : 8'(addr >> 3);
        good = (size == 4'd8) && (addr[2:0] == 3'b000);
        @(negedge clk);
        if (mm) begin
            mm_req = 1; mm_we = we; mm_addr = addr; mm_size = size; mm_wdata = d;
        end else begin
            cfg_req = 1; cfg_we = we; cfg_addr = addr; cfg_size = size; cfg_wdata = d;
        end
        old62   = m_ctrl[62];
        exp_rd  = good ? mdl_read(idx) : ONES;
        exp_err = !good;
        if (good && we) exp_err = mdl_write(idx, d, mm);
        @(posedge clk);
        @(negedge clk);
        cfg_req = 0; mm_req = 0;
        if (mm) begin
            chk(mm_ack == 1'b1, {"R12 mm ack ", tag}, 64'(mm_ack), 64'd1);
            chk(mm_err == exp_err, {"R8 mm err ", tag}, 64'(mm_err), 64'(exp_err));
            if (!we) chk(mm_rdata == exp_rd, {"R1 mm rdata ", tag}, mm_rdata, exp_rd);
        end else begin
            chk(cfg_ack == 1'b1, {"R12 cfg ack ", tag}, 64'(cfg_ack), 64'd1);
            chk(cfg_err == exp_err, {"R8 cfg err ", tag}, 64'(cfg_err), 64'(exp_err));
            if (!we) chk(cfg_rdata == exp_rd, {"R1 cfg rdata ", tag}, cfg_rdata, exp_rd);
        end
        chk(mmen_flip == (old62 ^ m_ctrl[62]), {"R10 flip ", tag}, 64'(mmen_flip), 64'(old62 ^ m_ctrl[62]));
    endtask

    task automatic rd_cfg(input logic [7:0] idx, input string tag);
        access(1'b0, 1'b0, addr_of(idx, 1'b0), 4'd8, 64'h0, tag);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        summary();
    end

    logic [7:0] picks [11] = '{8'h00, 8'h01, 8'h02, 8'h0A, 8'h0B, 8'h0E, 8'h12, 8'h13, 8'h15, 8'h07, 8'h30};

    initial begin
        rst = 1; cfg_req = 0; cfg_we = 0; cfg_addr = '0; cfg_size = 4'd8; cfg_wdata = '0;
        mm_req = 0; mm_we = 0; mm_addr = '0; mm_size = 4'd8; mm_wdata = '0; stat_in = '0;
        m_fault = '0; m_spbase = '0; m_ctrl = '0; m_stat = '0;
        m_base = (BRST & 64'h0003_FFFF_FFF0_0000) | 64'h1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(cfg_ack == 0 && mm_ack == 0 && cfg_err == 0, "R9 idle after reset", 64'(cfg_ack), 64'd0);
        // R9 reset values
        rd_cfg(8'h00, "R9 fault");
        rd_cfg(8'h0A, "R9 base");
        rd_cfg(8'h0B, "R9 spbase");
        rd_cfg(8'h0E, "R9 ctrl");
        rd_cfg(8'h15, "R9 stat");

        // R2 fault aliases
        access(0, 1, addr_of(8'h00, 0), 4'd8, 64'hF0F0_0000_FFFF_1234, "R2 wr");
        access(0, 1, addr_of(8'h01, 0), 4'd8, 64'hFF00_FFFF_0F0F_FFFF, "R2 and");
        access(1, 1, addr_of(8'h02, 1), 4'd8, 64'h0000_0001_0000_0008, "R2 or mm");
        rd_cfg(8'h00, "R2 readback");
        // R3 control aliases, bit 62 toggling for R10
        access(0, 1, addr_of(8'h0E, 0), 4'd8, 64'h0000_0000_0000_00F0, "R3 wr");
        access(0, 1, addr_of(8'h12, 0), 4'd8, 64'h4000_0000_0000_0003, "R3 set R10");
        access(1, 1, addr_of(8'h13, 1), 4'd8, 64'h4000_0000_0000_0011, "R3 clr R10");
        access(1, 0, addr_of(8'h0E, 1), 4'd8, 64'h0, "R1 mm ctrl");
        // R4 base
        access(0, 1, addr_of(8'h0A, 0), 4'd8, ONES, "R4 cfg wr");
        access(1, 1, 11'h000, 4'd8, 64'h0, "R4 mm rejected");
        access(1, 0, 11'h000, 4'd8, 64'h0, "R4 mm read");
        // R5
        access(1, 1, 11'h008, 4'd8, ONES, "R5 spbase");
        rd_cfg(8'h0B, "R5 readback");
        // R6 status
        @(negedge clk); stat_in = 64'hDEAD_BEEF_0000_0005;
        @(posedge clk); m_stat = stat_in;
        access(1, 0, 11'h058, 4'd8, 64'h0, "R6 mm stat");
        access(0, 1, addr_of(8'h15, 0), 4'd8, 64'h0, "R6 write");
        rd_cfg(8'h15, "R6 unchanged");
        // R7 alias and empty reads, empty write
        rd_cfg(8'h12, "R7 alias");
        rd_cfg(8'h07, "R7 empty");
        access(0, 1, addr_of(8'h30, 0), 4'd8, 64'h5, "R7 empty wr");
        // R8 malformed
        access(0, 0, addr_of(8'h00, 0), 4'd4, 64'h0, "R8 size4 rd");
        access(0, 1, addr_of(8'h00, 0) | 11'h4, 4'd8, 64'h0, "R8 misaligned wr");
        access(1, 1, addr_of(8'h0E, 1), 4'd2, ONES, "R8 mm size2 wr");
        rd_cfg(8'h00, "R8 fault kept");
        rd_cfg(8'h0E, "R8 ctrl kept");

        // R11 collision
        begin
            bit ig;
            @(negedge clk);
            cfg_req = 1; cfg_we = 1; cfg_addr = addr_of(8'h12, 0); cfg_size = 8; cfg_wdata = 64'h4000_0000_0000_0100;
            mm_req = 1; mm_we = 1; mm_addr = addr_of(8'h02, 1); mm_size = 8; mm_wdata = 64'h0000_0000_0000_0C00;
            #1;
            chk(mm_gnt == 0, "R11 gnt low", 64'(mm_gnt), 64'd0);
            ig = mdl_write(8'h12, 64'h4000_0000_0000_0100, 0);
            @(posedge clk); @(negedge clk);
            cfg_req = 0;
            chk(cfg_ack == 1 && mm_ack == 0, "R11 cfg wins", 64'({cfg_ack, mm_ack}), 64'h2);
            #1;
            chk(mm_gnt == 1, "R11 gnt back", 64'(mm_gnt), 64'd1);
            ig = mdl_write(8'h02, 64'h0000_0000_0000_0C00, 1);
            @(posedge clk); @(negedge clk);
            mm_req = 0;
            chk(mm_ack == 1 && mm_err == 0, "R11 retry ack", 64'({mm_ack, mm_err}), 64'h2);
            rd_cfg(8'h00, "R11 fault");
            rd_cfg(8'h0E, "R11 ctrl");
        end

        // constrained random
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 400; i++) begin
            logic [7:0]  idx;
            bit          mm, we;
            logic [3:0]  sz;
            logic [63:0] d;
            idx = picks[$urandom_range(0, 10)];
            mm  = $urandom_range(0, 1);
            we  = $urandom_range(0, 1);
            sz  = ($urandom_range(0, 9) == 0) ? 4'd4 : 4'd8;
            d   = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) d[62] = ~m_ctrl[62];
            access(mm, we, addr_of(idx, mm), sz, d, "R1 random");
        end
        summary();
    end
endmodule